// File: doc/BRIEF.md
# Instruction Cache Fill Scope Decision Unit

This unit sits beside the instruction fetch path and decides, for each instruction-side event, which pages the cache fill engine may bring into the instruction cache or into a combined cache. A caller presents one event per clock. The event carries the execution and nullification status, any interruption, the branch outcome and target, the space and TLB attributes of the page, and the result of the external protection check on the following page. One clock later the unit reports the primary page it may fill, whether the sequentially following page may also be filled and which page that is, and whether the fetch falls into an undefined combined-TLB case.

Pages are 4 KB on a 32-bit address and instructions are 4 bytes wide. The "own" page of the instruction is the physical page when the translation control bit is 0 and the virtual page when it is 1. The following page is always the chosen page plus one. Wraparound at the top of the page space is not treated specially.

The decision is held in an enumerated state register, and the outputs are decoded from that register. The states are `SC_NONE` (no fill), `SC_OWN` (own page only), `SC_OWN_NEXT` (own page and, if permitted, the following one), `SC_TGT` (branch target page only) and `SC_TGT_NEXT` (target page and, if permitted, the following one). On every clock the unit enters exactly one state, chosen from the incoming event by the first rule that matches in this order:
- blocked (no execution, I/O space, or interruption 6 or 7) goes to `SC_NONE`
- a nullified instruction goes to `SC_OWN`
- a group-4 interruption on a live branch goes to `SC_TGT`
- a live branch whose target is the last word of its page, with a trapping delay slot, goes to `SC_TGT_NEXT`
- any other live branch goes to `SC_TGT`
- every other event goes to `SC_OWN_NEXT`

Reset forces `SC_NONE`.

Top module: `ifill_scope`

## Requirements
- R1: When `exec_vld` is 0, the next cycle shows `fill_vld`=0, `fill_page`=0, `next_vld`=0 and `next_page`=0.
- R2: A plainly executed instruction gives `fill_vld`=1, with `fill_page` equal to `phys_page` when `c_bit`=0 and to `virt_page` when `c_bit`=1. It also gives `next_vld`=1 with `next_page` equal to `fill_page`+1, provided `next_page_permit`=1.
- R3: With `next_page_permit`=0, `next_vld` is 0 and `next_page` is 0 in the following cycle, whatever the event.
- R4: A nullified instruction (`nullified`=1) fills only its own page (`next_vld`=0). This also applies when it is a taken branch.
- R5: A live branch (`br_vld`=1, `br_taken`=1, `br_nullified`=0) fills the page `br_target[31:12]` and does not fill the following page, unless R6 applies.
- R6: If a live branch has a target whose byte offset within its page is at least 4092 (the last instruction of the page) and `slot_trap`=1, then `next_vld`=1 and `next_page` equals the target page plus 1, subject to R3.
- R7: An untaken branch (`br_taken`=0) or a nullified branch (`br_nullified`=1) never fills the target page; it is treated as a plain instruction as in R2.
- R8: A live branch with `br_grp4`=1 fills the target page only, with `next_vld`=0, even when `slot_trap`=1 and the target is the last instruction of its page.
- R9: `intr_vld`=1 with `intr_num` equal to 6 or 7 suppresses all fill (`fill_vld`=0, `next_vld`=0). Any other interruption number does not change the decision.
- R10: `io_space`=1 suppresses all fill, including for taken branches.
- R11: `undef_flag` is 1 in the cycle after an event with `exec_vld`=1, `combined_tlb`=1 and `u_bit`=1, and 0 otherwise. It does not change the fill decision.
- R12: Every output is registered: the outputs change only one clock edge after the event that causes them, and the active-low asynchronous reset clears them all to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_vld | input | 1 | An instruction event is presented this cycle |
| nullified | input | 1 | The instruction is nullified |
| intr_vld | input | 1 | The instruction takes an interruption |
| intr_num | input | 5 | Interruption number |
| br_vld | input | 1 | The instruction is a branch |
| br_taken | input | 1 | The branch is taken |
| br_nullified | input | 1 | The branch itself is nullified |
| br_target | input | 32 | Branch target byte address |
| slot_trap | input | 1 | The delay-slot instruction traps |
| br_grp4 | input | 1 | The branch takes a group-4 interruption |
| c_bit | input | 1 | 0: own page is physical, 1: own page is virtual |
| phys_page | input | 20 | Physical page number of the instruction |
| virt_page | input | 20 | Virtual page number of the instruction |
| io_space | input | 1 | The page lies in I/O space |
| combined_tlb | input | 1 | The TLB is shared by instructions and data |
| u_bit | input | 1 | Uncacheable bit of the page |
| next_page_permit | input | 1 | The following page passes the access and protection checks |
| fill_vld | output | 1 | The primary page may be filled |
| fill_page | output | 20 | Primary page number |
| next_vld | output | 1 | The following page may be filled |
| next_page | output | 20 | Following page number |
| undef_flag | output | 1 | The fetch is an undefined combined-TLB uncacheable case |

## Verification
The assertions check on every cycle the properties that follow from one event: suppression after no execution, after I/O space or after interruptions 6 and 7; the absence of a following page after nullification, after a denied permit or after a group-4 branch; the following page being one above the primary page; and the primary page of an untaken branch being the instruction's own page. Only the bench scenarios can show the exact page values for each state, the corner cases of the last word on a page (offset 4092 against 4088), the exact priority between competing conditions, the one-cycle hold of the outputs and the effect of reset in mid-run.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
    // Decision states of the fill scope unit
    typedef enum logic [2:0] {
        SC_NONE     = 3'd0,
        SC_OWN      = 3'd1,
        SC_OWN_NEXT = 3'd2,
        SC_TGT      = 3'd3,
        SC_TGT_NEXT = 3'd4
    } scope_e;

    // Interruptions that forbid any instruction-side fill
    localparam int ITLB_MISS_NUM  = 6;
    localparam int IPROT_TRAP_NUM = 7;
endpackage

// File: rtl/ifs_classify.sv
module ifs_classify
    import ifs_pkg::*;
#(
    parameter int INTR_W     = 5,
    parameter int OFF_W      = 12,
    parameter int INSTR_LOG2 = 2
) (
    input  logic              exec_vld,
    input  logic              nullified,
    input  logic              intr_vld,
    input  logic [INTR_W-1:0] intr_num,
    input  logic              br_vld,
    input  logic              br_taken,
    input  logic              br_nullified,
    input  logic [OFF_W-1:0]  tgt_off,
    input  logic              slot_trap,
    input  logic              br_grp4,
    input  logic              io_space,
    output scope_e            scope_d
);
    localparam int          PAGE_BYTES = 1 << OFF_W;
    localparam int          LAST_OFF   = PAGE_BYTES - (1 << INSTR_LOG2);
    localparam logic [OFF_W-1:0] LAST_OFF_V = OFF_W'(LAST_OFF);

    logic fetch_trap;
    logic blocked;
    logic br_live;
    logic tgt_last;

    always_comb begin
        fetch_trap = intr_vld && ((intr_num == INTR_W'(ITLB_MISS_NUM)) ||
                                  (intr_num == INTR_W'(IPROT_TRAP_NUM)));
        blocked    = !exec_vld || io_space || fetch_trap;
        br_live    = br_vld && br_taken && !br_nullified;
        tgt_last   = (tgt_off >= LAST_OFF_V);

        if (blocked) begin
            scope_d = SC_NONE;
        end else if (nullified) begin
            scope_d = SC_OWN;
        end else if (br_live && br_grp4) begin
            scope_d = SC_TGT;
        end else if (br_live && slot_trap && tgt_last) begin
            scope_d = SC_TGT_NEXT;
        end else if (br_live) begin
            scope_d = SC_TGT;
        end else begin
            scope_d = SC_OWN_NEXT;
        end
    end
endmodule

// File: rtl/ifs_page_sel.sv
module ifs_page_sel
    import ifs_pkg::*;
#(
    parameter int PAGE_W = 20
) (
    input  scope_e            scope_d,
    input  logic              c_bit,
    input  logic [PAGE_W-1:0] phys_page,
    input  logic [PAGE_W-1:0] virt_page,
    input  logic [PAGE_W-1:0] tgt_page,
    output logic [PAGE_W-1:0] prim_d,
    output logic [PAGE_W-1:0] succ_d
);
    localparam logic [PAGE_W-1:0] ONE_PG = PAGE_W'(1);

    logic [PAGE_W-1:0] own_page;

    always_comb begin
        own_page = c_bit ? virt_page : phys_page;
        unique case (scope_d)
            SC_OWN: begin
                prim_d = own_page;
                succ_d = '0;
            end
            SC_OWN_NEXT: begin
                prim_d = own_page;
                succ_d = own_page + ONE_PG;
            end
            SC_TGT: begin
                prim_d = tgt_page;
                succ_d = '0;
            end
            SC_TGT_NEXT: begin
                prim_d = tgt_page;
                succ_d = tgt_page + ONE_PG;
            end
            default: begin
                prim_d = '0;
                succ_d = '0;
            end
        endcase
    end
endmodule

// File: rtl/ifill_scope.sv
module ifill_scope
    import ifs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 12,
    parameter int INSTR_LOG2 = 2,
    parameter int INTR_W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exec_vld,
    input  logic                nullified,
    input  logic                intr_vld,
    input  logic [INTR_W-1:0]   intr_num,
    input  logic                br_vld,
    input  logic                br_taken,
    input  logic                br_nullified,
    input  logic [ADDR_W-1:0]   br_target,
    input  logic                slot_trap,
    input  logic                br_grp4,
    input  logic                c_bit,
    input  logic [ADDR_W-OFF_W-1:0] phys_page,
    input  logic [ADDR_W-OFF_W-1:0] virt_page,
    input  logic                io_space,
    input  logic                combined_tlb,
    input  logic                u_bit,
    input  logic                next_page_permit,
    output logic                fill_vld,
    output logic [ADDR_W-OFF_W-1:0] fill_page,
    output logic                next_vld,
    output logic [ADDR_W-OFF_W-1:0] next_page,
    output logic                undef_flag
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [PAGE_W-1:0] ONE_PG = PAGE_W'(1);

    scope_e            scope_d, scope_q;
    logic [PAGE_W-1:0] prim_d, succ_d, prim_q, succ_q;
    logic              permit_q;
    logic              undef_q;

    ifs_classify #(
        .INTR_W     (INTR_W),
        .OFF_W      (OFF_W),
        .INSTR_LOG2 (INSTR_LOG2)
    ) u_classify (
        .exec_vld     (exec_vld),
        .nullified    (nullified),
        .intr_vld     (intr_vld),
        .intr_num     (intr_num),
        .br_vld       (br_vld),
        .br_taken     (br_taken),
        .br_nullified (br_nullified),
        .tgt_off      (br_target[OFF_W-1:0]),
        .slot_trap    (slot_trap),
        .br_grp4      (br_grp4),
        .io_space     (io_space),
        .scope_d      (scope_d)
    );

    ifs_page_sel #(
        .PAGE_W (PAGE_W)
    ) u_page_sel (
        .scope_d   (scope_d),
        .c_bit     (c_bit),
        .phys_page (phys_page),
        .virt_page (virt_page),
        .tgt_page  (br_target[ADDR_W-1:OFF_W]),
        .prim_d    (prim_d),
        .succ_d    (succ_d)
    );

    // State register: one decision per event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scope_q  <= SC_NONE;
            prim_q   <= '0;
            succ_q   <= '0;
            permit_q <= 1'b0;
            undef_q  <= 1'b0;
        end else begin
            scope_q  <= scope_d;
            prim_q   <= prim_d;
            succ_q   <= succ_d;
            permit_q <= next_page_permit;
            undef_q  <= exec_vld && combined_tlb && u_bit;
        end
    end

    // Output decode from the held state
    always_comb begin
        fill_vld   = 1'b0;
        fill_page  = '0;
        next_vld   = 1'b0;
        next_page  = '0;
        undef_flag = undef_q;
        unique case (scope_q)
            SC_OWN, SC_TGT: begin
                fill_vld  = 1'b1;
                fill_page = prim_q;
            end
            SC_OWN_NEXT, SC_TGT_NEXT: begin
                fill_vld  = 1'b1;
                fill_page = prim_q;
                next_vld  = permit_q;
                next_page = permit_q ? succ_q : '0;
            end
            default: begin
                fill_vld = 1'b0;
            end
        endcase
    end

    // R1
    idle_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_vld |=> (!fill_vld && !next_vld));

    // R3
    permit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !next_page_permit |=> !next_vld);

    // R4
    nullified_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && nullified) |=> !next_vld);

    // R2
    succ_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_vld |-> (fill_vld && (next_page == fill_page + ONE_PG)));

    // R7
    untaken_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && !io_space && !intr_vld && br_vld && !br_taken) |=>
            (fill_vld && fill_page == ($past(c_bit) ? $past(virt_page) : $past(phys_page))));

    // R8
    grp4_nosucc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && br_vld && br_taken && !br_nullified && br_grp4) |=> !next_vld);

    // R9
    fetch_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_vld && (intr_num == INTR_W'(ITLB_MISS_NUM) || intr_num == INTR_W'(IPROT_TRAP_NUM)))
            |=> !fill_vld);

    // R10
    io_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_space |=> (!fill_vld && !next_vld));
endmodule

// File: tb/ifill_scope_tb.sv
module ifill_scope_tb;
    typedef struct packed {
        logic [7:0]  rq;
        logic        ex, nu, iv;
        logic [4:0]  inum;
        logic        bv, bt, bn, st, g4, cb, pm, io;
        logic [31:0] tgt;
        logic        ef;
        logic [19:0] efp;
        logic        en;
        logic [19:0] enp;
    } vec_t;

    localparam logic [19:0] PP = 20'h12345;
    localparam logic [19:0] VP = 20'h0ABCD;
    localparam int NV = 19;
    localparam logic O = 1'b1;
    localparam logic Z = 1'b0;

    localparam vec_t VT [NV] = '{
        // R1 no execution
        '{8'd1, Z,Z,Z,5'd0, Z,Z,Z,Z,Z,Z,O,Z, 32'h0,         Z,20'h0,     Z,20'h0},
        // R2 physical own page
        '{8'd2, O,Z,Z,5'd0, Z,Z,Z,Z,Z,Z,O,Z, 32'h0,         O,20'h12345, O,20'h12346},
        // R2 virtual own page
        '{8'd2, O,Z,Z,5'd0, Z,Z,Z,Z,Z,O,O,Z, 32'h0,         O,20'h0ABCD, O,20'h0ABCE},
        // R3 permit denied
        '{8'd3, O,Z,Z,5'd0, Z,Z,Z,Z,Z,Z,Z,Z, 32'h0,         O,20'h12345, Z,20'h0},
        // R4 nullified plain
        '{8'd4, O,O,Z,5'd0, Z,Z,Z,Z,Z,Z,O,Z, 32'h0,         O,20'h12345, Z,20'h0},
        // R5 taken, mid page
        '{8'd5, O,Z,Z,5'd0, O,O,Z,Z,Z,Z,O,Z, 32'h77777010,  O,20'h77777, Z,20'h0},
        // R5 taken, last word, no slot trap
        '{8'd5, O,Z,Z,5'd0, O,O,Z,Z,Z,Z,O,Z, 32'h77777FFC,  O,20'h77777, Z,20'h0},
        // R6 last word with slot trap
        '{8'd6, O,Z,Z,5'd0, O,O,Z,O,Z,Z,O,Z, 32'h77777FFC,  O,20'h77777, O,20'h77778},
        // R6 last word with slot trap, permit denied
        '{8'd6, O,Z,Z,5'd0, O,O,Z,O,Z,Z,Z,Z, 32'h77777FFC,  O,20'h77777, Z,20'h0},
        // R6 one word before last
        '{8'd6, O,Z,Z,5'd0, O,O,Z,O,Z,Z,O,Z, 32'h77777FF8,  O,20'h77777, Z,20'h0},
        // R7 untaken branch
        '{8'd7, O,Z,Z,5'd0, O,Z,Z,O,Z,Z,O,Z, 32'h77777FFC,  O,20'h12345, O,20'h12346},
        // R7 nullified branch
        '{8'd7, O,Z,Z,5'd0, O,O,O,O,Z,O,O,Z, 32'h77777FFC,  O,20'h0ABCD, O,20'h0ABCE},
        // R8 group-4 on live branch
        '{8'd8, O,Z,Z,5'd0, O,O,Z,O,O,Z,O,Z, 32'h77777FFC,  O,20'h77777, Z,20'h0},
        // R9 interruption 6
        '{8'd9, O,Z,O,5'd6, Z,Z,Z,Z,Z,Z,O,Z, 32'h0,         Z,20'h0,     Z,20'h0},
        // R9 interruption 7 on branch
        '{8'd9, O,Z,O,5'd7, O,O,Z,Z,Z,O,O,Z, 32'h77777010,  Z,20'h0,     Z,20'h0},
        // R9 interruption 8 does not suppress
        '{8'd9, O,Z,O,5'd8, Z,Z,Z,Z,Z,Z,O,Z, 32'h0,         O,20'h12345, O,20'h12346},
        // R10 I/O space plain
        '{8'd10,O,Z,Z,5'd0, Z,Z,Z,Z,Z,Z,O,O, 32'h0,         Z,20'h0,     Z,20'h0},
        // R10 I/O space taken branch
        '{8'd10,O,Z,Z,5'd0, O,O,Z,O,Z,Z,O,O, 32'h77777FFC,  Z,20'h0,     Z,20'h0},
        // R4 nullified taken branch keeps own page
        '{8'd4, O,O,Z,5'd0, O,O,Z,O,Z,Z,O,Z, 32'h77777FFC,  O,20'h12345, Z,20'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_vld = 1'b0, nullified = 1'b0, intr_vld = 1'b0;
    logic [4:0]  intr_num = '0;
    logic        br_vld = 1'b0, br_taken = 1'b0, br_nullified = 1'b0;
    logic [31:0] br_target = '0;
    logic        slot_trap = 1'b0, br_grp4 = 1'b0, c_bit = 1'b0;
    logic [19:0] phys_page = PP, virt_page = VP;
    logic        io_space = 1'b0, combined_tlb = 1'b0, u_bit = 1'b0;
    logic        next_page_permit = 1'b0;
    logic        fill_vld, next_vld, undef_flag;
    logic [19:0] fill_page, next_page;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ifill_scope u_dut (
        .clk(clk), .rst_n(rst_n), .exec_vld(exec_vld), .nullified(nullified),
        .intr_vld(intr_vld), .intr_num(intr_num), .br_vld(br_vld),
        .br_taken(br_taken), .br_nullified(br_nullified), .br_target(br_target),
        .slot_trap(slot_trap), .br_grp4(br_grp4), .c_bit(c_bit),
        .phys_page(phys_page), .virt_page(virt_page), .io_space(io_space),
        .combined_tlb(combined_tlb), .u_bit(u_bit),
        .next_page_permit(next_page_permit), .fill_vld(fill_vld),
        .fill_page(fill_page), .next_vld(next_vld), .next_page(next_page),
        .undef_flag(undef_flag)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        exec_vld = v.ex; nullified = v.nu; intr_vld = v.iv; intr_num = v.inum;
        br_vld = v.bv; br_taken = v.bt; br_nullified = v.bn; slot_trap = v.st;
        br_grp4 = v.g4; c_bit = v.cb; next_page_permit = v.pm; io_space = v.io;
        br_target = v.tgt;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R12 outputs cleared while in reset
        repeat (2) @(negedge clk);
        chk("R12 reset fill_vld", 32'(fill_vld), 32'h0);
        chk("R12 reset next_vld", 32'(next_vld), 32'h0);
        chk("R12 reset undef_flag", 32'(undef_flag), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VT[i]);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d fill_vld", VT[i].rq, i), 32'(fill_vld), 32'(VT[i].ef));
            chk($sformatf("R%0d vec%0d fill_page", VT[i].rq, i), 32'(fill_page), 32'(VT[i].efp));
            chk($sformatf("R%0d vec%0d next_vld", VT[i].rq, i), 32'(next_vld), 32'(VT[i].en));
            chk($sformatf("R%0d vec%0d next_page", VT[i].rq, i), 32'(next_page), 32'(VT[i].enp));
        end

        // R11 undefined combined-TLB uncacheable fetch
        apply(VT[1]);
        combined_tlb = 1'b1; u_bit = 1'b1;
        @(negedge clk);
        chk("R11 undef set", 32'(undef_flag), 32'h1);
        chk("R11 fill unaffected", 32'(fill_page), 32'(PP));
        u_bit = 1'b0;
        @(negedge clk);
        chk("R11 u_bit clear", 32'(undef_flag), 32'h0);
        combined_tlb = 1'b0; u_bit = 1'b1;
        @(negedge clk);
        chk("R11 split TLB", 32'(undef_flag), 32'h0);
        combined_tlb = 1'b1; exec_vld = 1'b0;
        @(negedge clk);
        chk("R11 no execution", 32'(undef_flag), 32'h0);
        combined_tlb = 1'b0; u_bit = 1'b0;

        // R12 outputs held until the next edge
        apply(VT[2]);
        @(negedge clk);
        apply(VT[0]);
        #5;
        chk("R12 hold fill_page", 32'(fill_page), 32'(VP));
        chk("R12 hold next_vld", 32'(next_vld), 32'h1);
        @(negedge clk);
        chk("R12 after edge", 32'(fill_vld), 32'h0);

        // R12 asynchronous reset in mid-run
        apply(VT[7]);
        @(negedge clk);
        chk("R12 pre-reset next_page", 32'(next_page), 32'h77778);
        #3 rst_n = 1'b0;
        #1;
        chk("R12 async reset fill_vld", 32'(fill_vld), 32'h0);
        chk("R12 async reset next_page", 32'(next_page), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule